// File: doc/BRIEF.md
# LRU Tag Directory with Line-Crossing Lookups

This block tracks cache hits and misses without holding any data. It keeps a set-associative directory of line tags. Inside each set the ways form a recency list: way 0 holds the most recently used tag and the last way holds the least recently used one. A request gives a byte address and a byte count. The block decides whether every line the request touches is present, and it reorders the affected sets as an LRU cache would.

Requests arrive on a valid/ready channel. One cycle after a request completes, a single-cycle response appears with a miss flag and an error flag. If a request's last byte falls in the line after its first byte, the block looks up both sets on consecutive cycles. It holds ready low during the second cycle and reports a miss if either lookup missed. A request that spans more than two sets is refused with the error flag. A clear input invalidates the whole directory in one cycle.

Top module: `lru_tag_dir`

## Requirements
- R1: The line offset is the low log2(LINE_BYTES) address bits. The set index is the next log2(NUM_SETS) bits. The tag is all address bits above those. When the last byte (address + size − 1) lies in the same set as the first byte, the request takes one lookup, and rspValid is high exactly one cycle after the request is accepted.
- R2: A lookup whose tag matches no valid way is a miss. Every way moves down one position, the tag in the last way is lost, and the new tag is placed in way 0 as valid.
- R3: A lookup that matches way 0 is a hit and leaves the set unchanged.
- R4: A lookup that matches way i > 0 is a hit. Ways 0..i−1 each move down one position, the matched tag moves to way 0, and ways above i keep their contents.
- R5: When the last byte's set equals the first byte's set plus one (modulo NUM_SETS), the first set is looked up with the first tag in the accept cycle. The second set is looked up with the last byte's tag in the following cycle. reqReady is low during that second cycle. One response follows, with rspMiss high if either lookup missed.
- R6: A request that crosses from the highest set into set 0 is handled as a two-line request. The second tag is one greater than the first.
- R7: A request whose last byte's set is neither the first set nor the next one is answered one cycle later with rspErr high and rspMiss low. It changes no set.
- R8: While clear is high, reqReady is low. After a clear every way is invalid, so the next lookup of any tag misses, including tag value zero.
- R9: After reset every way is invalid, no response is pending, and reqReady is high.
- R10: With NUM_WAYS = 1 the directory behaves as direct-mapped: only way 0 is compared, and a miss replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Invalidate all ways |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be accepted this cycle |
| reqAddr | input | ADDR_W | Byte address of the first byte |
| reqSize | input | SIZE_W | Byte count, at least 1 |
| rspValid | output | 1 | Response strobe, one cycle |
| rspMiss | output | 1 | At least one touched line was absent |
| rspErr | output | 1 | Request spanned more than two sets |

## Verification
The assertions assume that a request is offered only with a nonzero byte count. They also assume that clear is not raised during the second half of a line-crossing request, since a clear there drops the response. The stimulus keeps every size in the range 1 to 40. It raises clear only while no crossing request is in flight. It reuses a small pool of addresses, so ways get evicted and reordered, and sizes above one line produce requests that span three sets. A direct-mapped instance runs beside the four-way one, and both are compared with a queue-based recency model on every clock.

// File: rtl/lru_dir_pkg.sv
package lru_dir_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic lookEn;     // perform a lookup and update this cycle
    logic useSecond;  // look up the saved end set/tag instead of the start
    logic capture;    // save end set/tag for the next cycle
    logic clearAll;   // invalidate every way
  } dirStrobe_t;

  typedef enum logic [1:0] {
    SPAN_ONE = 2'd0,
    SPAN_TWO = 2'd1,
    SPAN_BAD = 2'd2
  } spanKind_t;

endpackage

// File: rtl/lru_dir_path.sv
module lru_dir_path
  import lru_dir_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 6,
  parameter int LINE_BYTES = 16,
  parameter int NUM_SETS   = 8,
  parameter int NUM_WAYS   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dirStrobe_t        stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  output spanKind_t         span,
  output logic              lookMiss
);
  localparam int LINE_BITS = $clog2(LINE_BYTES);
  localparam int SET_BITS  = $clog2(NUM_SETS);
  localparam int LINE_W    = ADDR_W - LINE_BITS;
  localparam int TAG_W     = LINE_W - SET_BITS;

  logic [TAG_W-1:0]    tagMem [NUM_SETS][NUM_WAYS];
  logic [NUM_WAYS-1:0] vldMem [NUM_SETS];

  logic [TAG_W-1:0]    startTag, endTag, endTagQ, selTag;
  logic [SET_BITS-1:0] startSet, endSet, endSetQ, selSet;
  logic [NUM_WAYS-1:0] hitVec, shiftEn;

  // first and last line numbers of the request
  assign {startTag, startSet} = reqAddr[ADDR_W-1:LINE_BITS];
  assign {endTag, endSet} =
    LINE_W'((reqAddr + ADDR_W'(reqSize) - ADDR_W'(1)) >> LINE_BITS);

  always_comb begin
    if (endSet == startSet)                      span = SPAN_ONE;
    else if (endSet == startSet + SET_BITS'(1))  span = SPAN_TWO;
    else                                         span = SPAN_BAD;
  end

  assign selSet = stb.useSecond ? endSetQ : startSet;
  assign selTag = stb.useSecond ? endTagQ : startTag;

  generate
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
      assign hitVec[w] = vldMem[selSet][w] && (tagMem[selSet][w] == selTag);
    end
  endgenerate

  assign lookMiss = ~|hitVec;

  // way w>0 takes way w-1 when the hit lies at or above w, or on a miss
  always_comb begin
    logic above;
    above      = 1'b0;
    shiftEn[0] = 1'b1;
    for (int w = NUM_WAYS - 1; w >= 1; w--) begin
      above      = above | hitVec[w];
      shiftEn[w] = above | lookMiss;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      endSetQ <= '0;
      endTagQ <= '0;
      for (int s = 0; s < NUM_SETS; s++) begin
        vldMem[s] <= '0;
        for (int w = 0; w < NUM_WAYS; w++) tagMem[s][w] <= '0;
      end
    end else begin
      if (stb.capture) begin
        endSetQ <= endSet;
        endTagQ <= endTag;
      end
      if (stb.clearAll) begin
        for (int s = 0; s < NUM_SETS; s++) vldMem[s] <= '0;
      end else if (stb.lookEn) begin
        tagMem[selSet][0] <= selTag;
        vldMem[selSet][0] <= 1'b1;
        for (int w = 1; w < NUM_WAYS; w++) begin
          if (shiftEn[w]) begin
            tagMem[selSet][w] <= tagMem[selSet][w-1];
            vldMem[selSet][w] <= vldMem[selSet][w-1];
          end
        end
      end
    end
  end

endmodule

// File: rtl/lru_dir_ctrl.sv
module lru_dir_ctrl
  import lru_dir_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clear,
  input  logic       reqValid,
  input  spanKind_t  span,
  input  logic       lookMiss,
  output logic       reqReady,
  output dirStrobe_t stb,
  output logic       rspValid,
  output logic       rspMiss,
  output logic       rspErr
);
  typedef enum logic {ST_IDLE, ST_SECOND} ctrlState_t;

  ctrlState_t state;
  logic       firstMiss;
  logic       accept;

  assign reqReady = !clear && (state == ST_IDLE);
  assign accept   = reqValid && reqReady;

  always_comb begin
    stb          = '0;
    stb.clearAll = clear;
    if (!clear) begin
      if (state == ST_SECOND) begin
        stb.lookEn    = 1'b1;
        stb.useSecond = 1'b1;
      end else if (accept && span != SPAN_BAD) begin
        stb.lookEn  = 1'b1;
        stb.capture = (span == SPAN_TWO);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      firstMiss <= 1'b0;
      rspValid  <= 1'b0;
      rspMiss   <= 1'b0;
      rspErr    <= 1'b0;
    end else begin
      rspValid <= 1'b0;
      rspMiss  <= 1'b0;
      rspErr   <= 1'b0;
      if (clear) begin
        state <= ST_IDLE;
      end else if (state == ST_SECOND) begin
        rspValid <= 1'b1;
        rspMiss  <= firstMiss | lookMiss;
        state    <= ST_IDLE;
      end else if (accept) begin
        case (span)
          SPAN_ONE: begin
            rspValid <= 1'b1;
            rspMiss  <= lookMiss;
          end
          SPAN_TWO: begin
            firstMiss <= lookMiss;
            state     <= ST_SECOND;
          end
          default: begin
            rspValid <= 1'b1;
            rspErr   <= 1'b1;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/lru_tag_dir.sv
module lru_tag_dir
  import lru_dir_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 6,
  parameter int LINE_BYTES = 16,
  parameter int NUM_SETS   = 8,
  parameter int NUM_WAYS   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  output logic              rspValid,
  output logic              rspMiss,
  output logic              rspErr
);
  dirStrobe_t stb;
  spanKind_t  span;
  logic       lookMiss;

  lru_dir_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .clear(clear), .reqValid(reqValid),
    .span(span), .lookMiss(lookMiss), .reqReady(reqReady), .stb(stb),
    .rspValid(rspValid), .rspMiss(rspMiss), .rspErr(rspErr)
  );

  lru_dir_path #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LINE_BYTES(LINE_BYTES),
    .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)
  ) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr),
    .reqSize(reqSize), .span(span), .lookMiss(lookMiss)
  );

endmodule

// File: rtl/lru_tag_dir_chk.sv
module lru_tag_dir_chk #(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 6,
  parameter int LINE_BYTES = 16,
  parameter int NUM_SETS   = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              clear,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [SIZE_W-1:0] reqSize,
  input logic              rspValid,
  input logic              rspMiss,
  input logic              rspErr
);
  localparam int LB = $clog2(LINE_BYTES);
  localparam int SB = $clog2(NUM_SETS);

  logic          acc;
  logic [SB-1:0] firstSet, lastSet;
  logic          oneLine, twoLine;

  assign acc      = reqValid && reqReady;
  assign firstSet = reqAddr[LB +: SB];
  assign lastSet  = SB'((reqAddr + ADDR_W'(reqSize) - ADDR_W'(1)) >> LB);
  assign oneLine  = (firstSet == lastSet);
  assign twoLine  = (lastSet == firstSet + SB'(1));

  // R1
  size_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    acc |-> reqSize != '0);

  // R1
  one_line_rsp_chk: assert property (@(posedge clk) disable iff (!rstN || clear)
    (acc && oneLine) |=> rspValid && !rspErr);

  // R1
  no_stray_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ($past(acc) || $past(!reqReady && !clear)));

  // R5
  two_line_seq_chk: assert property (@(posedge clk) disable iff (!rstN || clear)
    (acc && twoLine && !oneLine) |=> (!reqReady && !rspValid) ##1 (rspValid && !rspErr));

  // R7
  wide_err_chk: assert property (@(posedge clk) disable iff (!rstN || clear)
    (acc && !oneLine && !twoLine) |=> rspValid && rspErr && !rspMiss);

  // R8
  clear_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |-> !reqReady);

  // R3
  repeat_hit_chk: assert property (@(posedge clk) disable iff (!rstN || clear)
    (acc && oneLine && $past(acc && oneLine) && !$past(clear)
     && reqAddr == $past(reqAddr) && reqSize == $past(reqSize))
    |=> rspValid && !rspMiss);

endmodule

bind lru_tag_dir lru_tag_dir_chk #(
  .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LINE_BYTES(LINE_BYTES), .NUM_SETS(NUM_SETS)
) u_chk (
  .clk(clk), .rstN(rstN), .clear(clear), .reqValid(reqValid),
  .reqReady(reqReady), .reqAddr(reqAddr), .reqSize(reqSize),
  .rspValid(rspValid), .rspMiss(rspMiss), .rspErr(rspErr)
);

// File: tb/lru_tag_dir_test.sv
module lru_tag_dir_test;
  localparam int AW = 32;
  localparam int SW = 6;
  localparam int NS = 8;

  logic clk = 1'b0, rstN = 1'b0, clear = 1'b0, reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [SW-1:0] reqSize = '0;
  logic rdyA, vA, mA, eA, rdyB, vB, mB, eB;

  always #10 clk = ~clk;  // 50 MHz

  lru_tag_dir #(.ADDR_W(AW), .SIZE_W(SW), .LINE_BYTES(16), .NUM_SETS(NS), .NUM_WAYS(4)) uut (
    .clk(clk), .rstN(rstN), .clear(clear), .reqValid(reqValid), .reqReady(rdyA),
    .reqAddr(reqAddr), .reqSize(reqSize), .rspValid(vA), .rspMiss(mA), .rspErr(eA));

  lru_tag_dir #(.ADDR_W(AW), .SIZE_W(SW), .LINE_BYTES(16), .NUM_SETS(NS), .NUM_WAYS(1)) uutDm (
    .clk(clk), .rstN(rstN), .clear(clear), .reqValid(reqValid), .reqReady(rdyB),
    .reqAddr(reqAddr), .reqSize(reqSize), .rspValid(vB), .rspMiss(mB), .rspErr(eB));

  int    checks = 0, errors = 0, cyc = 0;
  string phase = "R9";

  // reference: per config, per set, a recency queue (front = most recent)
  int dq[2][NS][$];
  bit pend = 0, expV = 0, expE = 0;
  bit expM[2], pMiss[2];
  int pSet = 0, pTag = 0;

  function automatic bit touch(int c, int s, int t);
    int ways = (c == 0) ? 4 : 1;
    for (int i = 0; i < dq[c][s].size(); i++) begin
      if (dq[c][s][i] == t) begin
        dq[c][s].delete(i);
        dq[c][s].push_front(t);
        return 1'b0;
      end
    end
    dq[c][s].push_front(t);
    if (dq[c][s].size() > ways) void'(dq[c][s].pop_back());
    return 1'b1;
  endfunction

  task automatic wipe();
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < NS; s++) dq[c][s].delete();
  endtask

  always @(posedge clk) begin
    expV = 0; expE = 0; expM[0] = 0; expM[1] = 0;
    if (!rstN) begin
      wipe();
      pend = 0;
    end else if (clear) begin
      wipe();
      pend = 0;
    end else if (pend) begin
      for (int c = 0; c < 2; c++) expM[c] = pMiss[c] | touch(c, pSet, pTag);
      expV = 1;
      pend = 0;
    end else if (reqValid) begin
      int a, e, s0, s1;
      a  = int'(reqAddr);
      e  = a + int'(reqSize) - 1;
      s0 = (a >> 4) & 7;
      s1 = (e >> 4) & 7;
      if (s0 == s1) begin
        for (int c = 0; c < 2; c++) expM[c] = touch(c, s0, a >> 7);
        expV = 1;
      end else if (((s0 + 1) & 7) == s1) begin
        for (int c = 0; c < 2; c++) pMiss[c] = touch(c, s0, a >> 7);
        pSet = s1;
        pTag = e >> 7;
        pend = 1;
      end else begin
        expV = 1;
        expE = 1;
      end
    end
  end

  task automatic chk(string what, int act, int exp, string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // compare both instances every cycle, halfway between edges
  always @(posedge clk) begin
    #5;
    if (!rstN) begin
      chk("rspValid in reset", int'(vA), 0, "R9");
      chk("rspValid in reset dm", int'(vB), 0, "R9");
    end else begin
      string rq;
      rq = pend ? "R5" : (clear ? "R8" : phase);
      chk("reqReady", int'(rdyA), int'(!clear && !pend), rq);
      chk("reqReady dm", int'(rdyB), int'(!clear && !pend), "R10");
      chk("rspValid", int'(vA), int'(expV), phase);
      chk("rspValid dm", int'(vB), int'(expV), "R10");
      chk("rspErr", int'(eA), int'(expE), expE ? "R7" : phase);
      chk("rspErr dm", int'(eB), int'(expE), "R10");
      if (expV) begin
        chk("rspMiss", int'(mA), int'(expM[0]), phase);
        chk("rspMiss dm", int'(mB), int'(expM[1]), "R10");
      end
    end
  end

  task automatic send(int a, int s);
    while (!rdyA) @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = AW'(a);
    reqSize  = SW'(s);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doClear();
    while (!rdyA) @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: cycles=%0d expected<150000", cyc);
      finishRun();
    end
  end

  initial begin
    int r;
    idle(3);
    rstN = 1'b1;
    idle(2);
    // R9: first lookups after reset miss, even for tag zero
    phase = "R9";  send(32'h000, 4);
    phase = "R3";  send(32'h000, 4); send(32'h008, 8);
    phase = "R2";  send(32'h080, 1); send(32'h100, 2); send(32'h180, 16);
    phase = "R4";  send(32'h004, 4); send(32'h104, 4);
    phase = "R2";  send(32'h200, 1); send(32'h080, 1); send(32'h180, 1);
    phase = "R1";  send(32'h310, 16); send(32'h31F, 1); idle(1);
    phase = "R5";  send(32'h01C, 8); send(32'h010, 1); send(32'h020, 1);
                   send(32'h02E, 4); send(32'h0AE, 4); send(32'h02E, 4);
    phase = "R6";  send(32'h07C, 8); send(32'h070, 1); send(32'h080, 1);
                   send(32'h0FF, 2);
    phase = "R7";  send(32'h0F0, 40); send(32'h0F0, 1); send(32'h004, 33);
                   send(32'h000, 1);
    phase = "R8";  doClear(); send(32'h000, 4); send(32'h000, 4); send(32'h01C, 8);
    idle(2);
    phase = "R2";
    r = 32'h1ACE;
    for (int i = 0; i < 400; i++) begin
      r = (r << 1) ^ (((r >> 19) ^ (r >> 16)) & 1);
      r = r & 32'hFFFFF;
      if ((r % 53) == 0) begin
        phase = "R8"; doClear(); phase = "R2";
      end
      send(r & 32'h3FF, 1 + ((r >> 10) % 40));
      if ((r & 7) == 0) idle(1);
    end
    idle(4);
    finishRun();
  end

endmodule